// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of a set of DMA channels the transfer engine serves next. Each channel can ask for service in two ways. One is a hardware request line from a peripheral. The other is a software start pulse, which sets a sticky start bit inside the arbiter. Hardware lines are registered first. They are then merged with the start bits into a single pending vector. One cycle later the arbiter picks a winner from that vector.

The winner is chosen by one of two policies, selected by a mode input. In fixed-priority mode the highest-numbered pending channel wins. In round-robin mode the search begins at the channel after the one granted last and wraps at the top. While the engine reports busy, no grant is issued. A grant is a one-cycle `grant_valid` strobe together with the channel number. The engine uses that number to form the address of the channel's descriptor.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, `grant_ch` is 0, no software start bit is set, and the first round-robin search starts at channel 0.
- R2: A hardware request that is high at clock edge k is registered at edge k. If the engine is idle, it is granted at edge k+1, so `grant_valid` is high in the cycle after edge k+1. The request line needs to be high for only one edge.
- R3: A registered hardware request takes part in arbitration only if its `ch_enable` bit is 1 at the arbitration edge. With the bit at 0, the request never produces a grant.
- R4: A `sw_start` pulse at edge k sets that channel's start bit, and the channel can be granted at edge k+1. The start bit ignores `ch_enable`, and it stays set until the channel is granted.
- R5: A channel's start bit clears at the edge that grants that channel. If a new `sw_start` pulse for the same channel arrives at that same edge, the bit stays set and the channel is granted again.
- R6: With `rr_mode` = 0, the highest-numbered pending channel wins.
- R7: With `rr_mode` = 1, the pending channels are searched from (last granted + 1) upward, wrapping from 15 to 0. Grants in either mode update the last-granted channel.
- R8: No grant is issued at an edge where `engine_busy` is 1. Pending start bits are kept until a later grant.
- R9: At every edge where `engine_busy` is 0 and at least one channel is pending, a grant is issued.
- R10: While `grant_valid` is 0, `grant_ch` keeps the number of the most recent grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 16 | Peripheral request line per channel |
| sw_start | input | 16 | Software start pulse per channel (sets a sticky bit) |
| ch_enable | input | 16 | Per-channel enable for hardware requests |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| engine_busy | input | 1 | Engine cannot accept a new channel |
| grant_valid | output | 1 | One-cycle strobe: a channel was granted |
| grant_ch | output | 4 | Granted channel number |

## Verification
The hardest case to reach is a software start pulse for a channel that lands on the very edge that grants and clears that channel's bit. The stimulus sets the bit, then repeats the pulse exactly one cycle later, when the first grant is made. It then expects a second grant of the same channel. A further hard case is a held start bit that must survive a long busy window. To reach it, the bench raises `engine_busy` right after each pulse and masks every hardware line, so only the sticky bit can produce the grant that follows. Round-robin wrap order is checked with all channels requesting at once. This makes the expected grant sequence a plain count modulo 16.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic {
      ARB_FIXED = 1'b0,
      ARB_ROUND = 1'b1
   } arb_mode_e;

   function automatic int wrap_add(input int base, input int step, input int n);
      return (base + step) % n;
   endfunction
endpackage

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hw_req,
   input  logic [NUM_CH-1:0] sw_start,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic              clr_valid,
   input  logic [CH_W-1:0]   clr_ch,
   output logic [NUM_CH-1:0] pending
);
   logic [NUM_CH-1:0] hw_q;
   logic [NUM_CH-1:0] start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) hw_q <= '0;
      else        hw_q <= hw_req;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_start
      logic hit;
      assign hit = clr_valid && (clr_ch == CH_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) start_q[g] <= 1'b0;
         else        start_q[g] <= sw_start[g] | (start_q[g] & ~hit);
      end
   end

   assign pending = (hw_q & ch_enable) | start_q;

   AST_START_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && !sw_start[clr_ch]) |=> !start_q[$past(clr_ch)]); // R5
   AST_START_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_valid && (start_q != '0)) |=> ((start_q & $past(start_q)) == $past(start_q))); // R8
endmodule

// File: rtl/dma_fixed_pick.sv
module dma_fixed_pick #(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] req,
   output logic              found,
   output logic [CH_W-1:0]   win
);
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (req[i]) begin
            found = 1'b1;
            win   = CH_W'(i);
         end
      end
   end
endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] req,
   input  logic [CH_W-1:0]   last,
   output logic              found,
   output logic [CH_W-1:0]   win
);
   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 1; k <= NUM_CH; k++) begin
         int idx;
         idx = wrap_add(int'(last), k, NUM_CH);
         if (!found && req[idx]) begin
            found = 1'b1;
            win   = CH_W'(idx);
         end
      end
   end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter bit RR_EN  = 1'b1,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hw_req,
   input  logic [NUM_CH-1:0] sw_start,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic              rr_mode,
   input  logic              engine_busy,
   output logic              grant_valid,
   output logic [CH_W-1:0]   grant_ch
);
   localparam logic [NUM_CH-1:0] ONE_HOT0 = NUM_CH'(1);

   if (NUM_CH < 2) begin : g_bad_count
      $error("dma_req_arbiter: NUM_CH must be at least 2");
   end

   logic [NUM_CH-1:0] pending;
   logic              fix_found, rr_found, fire;
   logic [CH_W-1:0]   fix_win, rr_win, sel_win, last_q;
   arb_mode_e         mode;

   dma_req_capture #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
      .ch_enable(ch_enable), .clr_valid(fire), .clr_ch(sel_win),
      .pending(pending)
   );

   dma_fixed_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fix (
      .req(pending), .found(fix_found), .win(fix_win)
   );

   if (RR_EN) begin : g_rr
      dma_rr_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rr (
         .req(pending), .last(last_q), .found(rr_found), .win(rr_win)
      );
      assign mode = rr_mode ? ARB_ROUND : ARB_FIXED;
   end else begin : g_fixed_only
      assign rr_found = fix_found;
      assign rr_win   = fix_win;
      assign mode     = ARB_FIXED;
   end

   assign sel_win = (mode == ARB_ROUND) ? rr_win : fix_win;
   assign fire    = !engine_busy && ((mode == ARB_ROUND) ? rr_found : fix_found);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_ch    <= '0;
         last_q      <= CH_W'(NUM_CH - 1);
      end else begin
         grant_valid <= fire;
         if (fire) begin
            grant_ch <= sel_win;
            last_q   <= sel_win;
         end
      end
   end

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(engine_busy) |-> !grant_valid); // R8
   AST_NO_IDLE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(engine_busy) && ($past(pending) != '0)) |-> grant_valid); // R9
   AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (($past(pending) & (ONE_HOT0 << grant_ch)) != '0)); // R3
   AST_FIXED_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !$past(rr_mode)) |-> (($past(pending) >> grant_ch) == ONE_HOT0)); // R6
   AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> $stable(grant_ch)); // R10
endmodule

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  hw_req = '0, sw_start = '0, ch_enable = '0;
   logic          rr_mode = 1'b0, engine_busy = 1'b0;
   logic          grant_valid;
   logic [3:0]    grant_ch;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   dma_req_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
      .ch_enable(ch_enable), .rr_mode(rr_mode), .engine_busy(engine_busy),
      .grant_valid(grant_valid), .grant_ch(grant_ch)
   );

   always #2.5 clk = ~clk;

   // Reference model built from the requirements
   logic [N-1:0] m_hwq, m_sw, m_pend, m_clr;
   int           m_last, w;
   logic         m_valid;
   logic [3:0]   m_ch;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hwq = '0; m_sw = '0; m_last = N - 1; m_valid = 0; m_ch = 0;
      end else begin
         m_pend = (m_hwq & ch_enable) | m_sw;
         m_clr  = '0;
         if (!engine_busy && m_pend != '0) begin
            w = 0;
            if (rr_mode) begin
               for (int k = N; k >= 1; k--)
                  if (m_pend[(m_last + k) % N]) w = (m_last + k) % N;
            end else begin
               for (int i = 0; i < N; i++) if (m_pend[i]) w = i;
            end
            m_valid = 1; m_ch = 4'(w); m_last = w;
            m_clr = N'(1) << w;
         end else begin
            m_valid = 0;
         end
         m_sw  = (m_sw & ~m_clr) | sw_start;
         m_hwq = hw_req;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input string tag);
      @(negedge clk);
      check({tag, " valid"}, 32'(grant_valid), 32'(m_valid));
      check(m_valid ? {tag, " ch"} : "R10 held ch", 32'(grant_ch), 32'(m_ch));
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", 32'(grant_valid), 0);
      check("R1 reset ch", 32'(grant_ch), 0);
      rst_n = 1'b1;
      ch_enable = '1;
      cyc("R1");
      // R1/R7: all channels requesting, round-robin from 0 upward with wrap
      rr_mode = 1; hw_req = '1;
      cyc("R7");
      for (int k = 0; k < 34; k++) begin
         cyc("R7");
         check("R7 rr order", 32'(grant_ch), 32'(k % N));
      end
      hw_req = '0; cyc("R7"); cyc("R7");
      // R2: single one-edge hardware pulse per channel, fixed mode
      rr_mode = 0;
      for (int c = 0; c < N; c++) begin
         hw_req = N'(1) << c; cyc("R2");
         hw_req = '0; cyc("R2");
         check("R2 latency", 32'(grant_valid), 1);
         cyc("R2"); cyc("R2");
      end
      // R3: masked hardware request never grants
      for (int c = 0; c < N; c++) begin
         ch_enable = ~(N'(1) << c); hw_req = N'(1) << c;
         cyc("R3"); cyc("R3"); cyc("R3");
         check("R3 masked", 32'(grant_valid), 0);
      end
      hw_req = '0; ch_enable = '1; cyc("R3");
      // R4/R8: start bit ignores mask and survives a busy window
      ch_enable = '0;
      for (int c = 0; c < N; c++) begin
         sw_start = N'(1) << c; cyc("R4");
         sw_start = '0; engine_busy = 1;
         for (int b = 0; b < 4; b++) cyc("R8");
         engine_busy = 0; cyc("R4"); cyc("R4");
         check("R4 sticky grant", 32'(grant_ch), 32'(c));
         cyc("R4");
      end
      // R5: second start pulse lands on the granting edge
      sw_start = N'(1) << 3; cyc("R5");
      cyc("R5");
      sw_start = '0; cyc("R5");
      check("R5 regrant", 32'(grant_valid), 1);
      check("R5 regrant ch", 32'(grant_ch), 3);
      cyc("R5");
      check("R5 cleared", 32'(grant_valid), 0);
      // R6/R7/R8/R9: random traffic in both modes
      for (int t = 0; t < 900; t++) begin
         rr_mode     = (t >= 300);
         hw_req      = N'($urandom);
         ch_enable   = N'($urandom);
         sw_start    = (($urandom % 4) == 0) ? N'(1) << ($urandom % N) : '0;
         engine_busy = (t >= 600) ? ($urandom % 3 == 0) : 1'b0;
         cyc(t < 300 ? "R6" : (t < 600 ? "R7" : "R9"));
      end
      hw_req = '0; sw_start = '0; engine_busy = 0;
      repeat (20) cyc("R9");
      done = 1;
      finish_run();
   end
endmodule